// File: doc/BRIEF.md
# Adaptive Idle-Timeout Sleep Controller

This block decides when a processing package may drop into its low-power state and when it must come back. It receives one bit of CPU activity, sampled on a slow strobe that stands for a 0.1 ms tick. It keeps track of a periodic operating-system tick that it can predict, which falls every 156 samples (15.6 ms). When the core has been idle for longer than a timeout, and the interval is still early enough for a useful stay, it raises a sleep request. Because the package needs 1 ms to power up, it lowers that request 10 samples before the next predicted tick, so the tick costs no latency. Activity that arrives while the package sleeps is an unpredicted hardware interrupt. It wakes the package at once and adds a 1 ms penalty to the latency count.

The timeout adapts once per OS tick. If the interval that just ended contained a latency event, the timeout returns to its maximum of 5 ms. Otherwise it halves its excess over a 1 ms floor. The block also keeps saturating counts of residency and latency, in samples, which a clear strobe resets. All times are integer counts of sample strobes.

Top module: `adaptive_sleep_ctl`

## Requirements
- R1: After reset, sleep_req and wake_req are 0, both counters are 0, and timeout_val is T_MAX (50).
- R2: The interval phase starts at 0 on the first sample after reset, advances by one on each sample, and wraps after OS_PERIOD-1 (155), the OS-tick sample. On an awake sample with cpu_active=0, the run of consecutive idle samples, including this one, is compared with timeout_val. If the run is greater and the phase is at most SLEEP_LIMIT (50), sleep_req rises in the next cycle.
- R3: An idle run that reaches the timeout only at a phase above SLEEP_LIMIT does not raise sleep_req in that interval.
- R4: Suppose the package is asleep at the sample with phase OS_PERIOD-1-WAKE_LEAD (145) and cpu_active=0. Then sleep_req falls and wake_req is 1 for exactly one cycle, and no latency is charged.
- R5: A sample with cpu_active=1 while asleep drops sleep_req at once, pulses wake_req for one cycle, adds LAT_PENALTY (10) to lat_count, and flags latency for the current interval.
- R6: At the OS-tick sample (phase 155), timeout_val becomes T_MAX if latency was flagged in the interval just ended. Otherwise it becomes ((T-10)>>1)+10, with T the old value: 50, 30, 20, 15, 12, 11, then 10.
- R7: res_count grows by one for each sample that finds sleep_req high.
- R8: Both counters saturate at all ones (2^CNT_W-1) and never wrap.
- R9: clr_stats zeroes both counters in the next cycle and takes priority over a same-cycle increment.
- R10: A cycle without sample_en changes no state. cpu_active is ignored on such cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | One-cycle strobe per 0.1 ms activity sample |
| cpu_active | input | 1 | Activity bit, valid when sample_en is high |
| clr_stats | input | 1 | Clears both counters |
| sleep_req | output | 1 | High while the package should be in its low-power state |
| wake_req | output | 1 | One-cycle pulse when sleep ends |
| timeout_val | output | TW | Current idle timeout in samples |
| lat_count | output | CNT_W | Saturating latency count in samples |
| res_count | output | CNT_W | Saturating residency count in samples |

## Verification
On every cycle, the assertions check four things. Sleep is never entered past the deadline phase. The package is never still asleep after the predicted-wake point. The timeout stays between its floor and its maximum. A wake pulse is never seen together with a sleep request. They also check that cycles without a sample strobe leave sleep_req and the timeout alone, and that an interrupt while asleep always produces a wake. Only the bench's scenarios can show the exact decay sequence across many intervals, the 10-sample latency charge, and counter saturation. The same holds for a clear racing an increment, and for an idle run whose timeout expires just past the deadline. The bench checks these against a sample-by-sample model, under random activity of varying density mixed with directed interrupt trains.

// File: rtl/adaptive_sleep_ctl.sv
module adaptive_sleep_ctl #(
  parameter int OS_PERIOD   = 156,
  parameter int WAKE_LEAD   = 10,
  parameter int SLEEP_LIMIT = 50,
  parameter int T_MAX       = 50,
  parameter int T_FLOOR     = 10,
  parameter int LAT_PENALTY = 10,
  parameter int CNT_W       = 16,
  localparam int TW = $clog2(T_MAX + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             cpu_active,
  input  logic             clr_stats,
  output logic             sleep_req,
  output logic             wake_req,
  output logic [TW-1:0]    timeout_val,
  output logic [CNT_W-1:0] lat_count,
  output logic [CNT_W-1:0] res_count
);
  localparam int PW = $clog2(OS_PERIOD);
  localparam logic [PW-1:0] PH_LAST  = PW'(OS_PERIOD - 1);
  localparam logic [PW-1:0] PH_WAKE  = PW'(OS_PERIOD - 1 - WAKE_LEAD);
  localparam logic [PW-1:0] PH_LIMIT = PW'(SLEEP_LIMIT);
  localparam logic [TW-1:0] T_HI = TW'(T_MAX);
  localparam logic [TW-1:0] T_LO = TW'(T_FLOOR);
  localparam logic [CNT_W-1:0] C_MAX = '1;
  localparam logic [CNT_W-1:0] C_PEN = CNT_W'(LAT_PENALTY);

  logic [PW-1:0] phase;
  logic [TW-1:0] idle_cnt, timeout;
  logic          asleep, lat_flag;
  logic [CNT_W-1:0] lat_cnt, res_cnt;

  wire os_edge   = (phase == PH_LAST);
  wire hw_irq    = asleep & cpu_active;
  wire pred_wake = asleep & ~cpu_active & (phase == PH_WAKE);
  wire missed    = lat_flag | hw_irq;

  wire [TW-1:0] idle_inc = (idle_cnt == '1) ? idle_cnt : idle_cnt + 1'b1;
  wire [TW-1:0] idle_nxt = cpu_active ? '0 : idle_inc;
  wire go_sleep = ~asleep & ~cpu_active & (idle_nxt > timeout) & (phase <= PH_LIMIT);
  wire [TW-1:0] t_decay = ((timeout - T_LO) >> 1) + T_LO;

  wire [CNT_W:0]    lat_sum = {1'b0, lat_cnt} + {1'b0, C_PEN};
  wire [CNT_W-1:0]  lat_inc = lat_sum[CNT_W] ? C_MAX : lat_sum[CNT_W-1:0];
  wire [CNT_W-1:0]  res_inc = (res_cnt == C_MAX) ? res_cnt : res_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= '0;
      idle_cnt <= '0;
      asleep   <= 1'b0;
      timeout  <= T_HI;
      lat_flag <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      wake_req <= sample_en & (hw_irq | pred_wake);
      if (sample_en) begin
        phase <= os_edge ? '0 : phase + 1'b1;
        if (asleep) begin
          idle_cnt <= '0;
          if (hw_irq || pred_wake) asleep <= 1'b0;
        end else begin
          idle_cnt <= idle_nxt;
          asleep   <= go_sleep;
        end
        if (os_edge) begin
          timeout  <= missed ? T_HI : t_decay;
          lat_flag <= 1'b0;
        end else if (hw_irq) begin
          lat_flag <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_stats) begin
      lat_cnt <= '0;
      res_cnt <= '0;
    end else if (sample_en) begin
      if (asleep) res_cnt <= res_inc;
      if (hw_irq) lat_cnt <= lat_inc;
    end
  end

  assign sleep_req   = asleep;
  assign timeout_val = timeout;
  assign lat_count   = lat_cnt;
  assign res_count   = res_cnt;

  // R3
  sleep_deadline_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(phase) <= PH_LIMIT);

  // R4
  wake_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> phase <= PH_WAKE);

  // R6
  timeout_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout >= T_LO && timeout <= T_HI);

  // R5
  irq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && hw_irq) |=> (wake_req && !sleep_req));

  // R4
  wake_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> !sleep_req);

  // R10
  no_sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> ($stable(sleep_req) && $stable(timeout_val)));

  // R8
  lat_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stats |=> lat_cnt >= $past(lat_cnt));
endmodule

// File: tb/tb_adaptive_sleep_ctl.sv
module tb_adaptive_sleep_ctl;
  localparam int CW  = 10;
  localparam int TWB = $clog2(50 + 1) + 1;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, sample_en = 1'b0, cpu_active = 1'b0, clr_stats = 1'b0;
  logic sleep_req, wake_req;
  logic [TWB-1:0] timeout_val;
  logic [CW-1:0] lat_count, res_count;

  adaptive_sleep_ctl #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .cpu_active(cpu_active),
    .clr_stats(clr_stats), .sleep_req(sleep_req), .wake_req(wake_req),
    .timeout_val(timeout_val), .lat_count(lat_count), .res_count(res_count));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int m_phase = 0, m_idle = 0, m_T = 50, m_lat = 0, m_res = 0;
  bit m_asleep = 0, m_flag = 0, m_wake = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (phase %0d)", tag, act, exp, m_phase);
    end
  endtask

  function automatic int sat(int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  function automatic int decay(int t, bit f);
    return f ? 50 : ((t - 10) >> 1) + 10;
  endfunction

  task automatic model(bit te, bit a, bit c);
    m_wake = 0;
    if (te) begin
      if (m_asleep) begin
        m_res = sat(m_res + 1);
        m_idle = 0;
        if (a) begin
          m_asleep = 0; m_wake = 1; m_flag = 1; m_lat = sat(m_lat + 10);
        end else if (m_phase == 145) begin
          m_asleep = 0; m_wake = 1;
        end
      end else begin
        m_idle = a ? 0 : m_idle + 1;
        if (!a && m_idle > m_T && m_phase <= 50) m_asleep = 1;
      end
      if (m_phase == 155) begin
        m_T = decay(m_T, m_flag); m_flag = 0; m_phase = 0;
      end else m_phase++;
    end
    if (c) begin m_lat = 0; m_res = 0; end
  endtask

  task automatic compare_all();
    chk("R2 R3 sleep_req", sleep_req, m_asleep);
    chk("R4 R5 wake_req", wake_req, m_wake);
    chk("R6 timeout_val", timeout_val, m_T);
    chk("R5 R8 lat_count", lat_count, m_lat);
    chk("R7 R8 res_count", res_count, m_res);
  endtask

  task automatic step(bit te, bit a, bit c);
    @(negedge clk);
    sample_en = te; cpu_active = a; clr_stats = c;
    @(posedge clk);
    #1;
    sample_en = 1'b0; clr_stats = 1'b0; cpu_active = $urandom % 2;
    model(te, a, c);
    @(negedge clk);
    compare_all();
  endtask

  task automatic run_random(int n, int rate);
    for (int i = 0; i < n; i++) begin
      bit a, te, c;
      te = ($urandom % 16) != 0;
      a  = (m_phase == 0) ? 1'b1 : (($urandom % rate) == 0);
      c  = ($urandom % 700) == 0;
      step(te, a, c);
    end
  endtask

  initial begin
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sleep_req", sleep_req, 0);
    chk("R1 wake_req", wake_req, 0);
    chk("R1 timeout_val", timeout_val, 50);
    chk("R1 lat_count", lat_count, 0);
    chk("R1 res_count", res_count, 0);

    // R6 decay chain over quiet intervals: 50,30,20,15,12,11,10
    for (int k = 0; k < 7; k++) begin
      for (int p = 0; p < 156; p++) step(1, p == 0, 0);
    end
    chk("R6 decayed to floor", timeout_val, 10);
    chk("R4 no latency on predicted wakes", lat_count, 0);

    // R3 late idle run: active until phase 45, timeout 10 expires at 56
    for (int p = 0; p < 156; p++) begin
      step(1, p <= 45, 0);
      if (p == 60) chk("R3 no late sleep", sleep_req, 0);
    end

    // R2 early idle run then R5 interrupt at phase 30
    for (int p = 0; p < 156; p++) begin
      step(1, p == 0 || p == 30, 0);
      if (p == 12) chk("R2 sleep entered", sleep_req, 1);
      if (p == 30) chk("R5 irq wake", wake_req, 1);
    end
    chk("R6 timeout back to max", timeout_val, 50);

    // R10 cycles without sample_en
    begin
      int t0, l0, r0;
      t0 = timeout_val; l0 = lat_count; r0 = res_count;
      for (int i = 0; i < 20; i++) step(0, 1, 0);
      chk("R10 timeout held", timeout_val, t0);
      chk("R10 lat held", lat_count, l0);
      chk("R10 res held", res_count, r0);
    end

    // random activity, light and heavy
    run_random(12000, 180);
    run_random(6000, 9);
    run_random(12000, 60);

    // R8 latency saturation: idle 0..50, interrupt at phase 60 each interval
    while (m_phase != 0) step(1, 0, 0);
    for (int k = 0; k < 110; k++)
      for (int p = 0; p < 156; p++) step(1, p == 60, 0);
    chk("R8 lat saturated", lat_count, CMAX);
    chk("R8 res saturated", res_count, CMAX);

    // R9 clear wins over same-cycle increment
    while (!sleep_req) step(1, 0, 0);
    step(1, 1, 1);
    chk("R9 lat cleared", lat_count, 0);
    chk("R9 res cleared", res_count, 0);

    run_random(3000, 40);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule